// File: doc/BRIEF.md
# Asynchronous DRAM Cycle Sequencer

This block sits between a synchronous host and a 64-bit asynchronous DRAM array that has no page mode. It accepts one request at a time over a valid/ready port: a read, a write or a read-modify-write. Each request carries a row address, a column address, a bank select, a bank-split mode bit, eight byte enables and 64 bits of write data. The block turns each request into one full RAS/CAS cycle. It drives a 12-bit address bus that carries first the row and then the column, two RAS strobes, eight byte-lane CAS strobes, and WE and OE strobe pairs that each cover one 32-bit half of the data bus. All strobes are active low.

The cycle type comes only from when WE falls relative to CAS. For a plain write, WE is already low when CAS falls (early write). For a read, WE stays high and OE is low while CAS is low. For a read-modify-write, the old data is read first. Then OE rises and WE falls while CAS is still held low (late write). Every strobe interval is a parameter counted in clock cycles.

A built-in interval timer starts CAS-before-RAS refresh cycles. A refresh that is pending is served before any waiting host request.

Top module: `async_dram_seq`

## Requirements
- R1: Out of reset, and whenever the sequencer is idle, every RAS, CAS, WE and OE strobe is high, DQ is released and `reqReady` is high. `reqReady` is low from the cycle after a request is accepted until the cycle completes.
- R2: `memAddr` carries the row when a RAS strobe falls and the column when CAS falls. CAS falls exactly `T_RCD` cycles after RAS.
- R3: A write (`reqOp` = 1) drives WE low before CAS falls and stores the write data in the enabled bytes.
- R4: A read (`reqOp` = 0) holds WE high and OE low while CAS is low. The block drives DQ only while one of its WE strobes is low. Captured data is returned with `rdValid` high for exactly one cycle, in the cycle after the last CAS-low cycle.
- R5: A read-modify-write (`reqOp` = 2) uses a single RAS/CAS assertion. It first returns the old data. Then OE rises and WE falls while CAS stays low, and the new bytes are written. WE and OE of one half are never low together.
- R6: `casN[i]` strobes byte lane i, which is data bits 8i+7..8i. Writes and read-modify-writes strobe only the enabled lanes. Reads strobe every lane of the selected bank. `rdData` lanes that were not strobed read as zero.
- R7: `weN[0]`/`oeN[0]` control lanes 0-3 (bits 31..0) and `weN[1]`/`oeN[1]` control lanes 4-7 (bits 63..32). Each strobe is asserted only when its half has a strobed lane.
- R8: With `bankSplit` = 0, both RAS strobes fall together. With `bankSplit` = 1, only `rasN[reqBank]` falls, and the lanes are limited to that bank's half (bank 0 is lanes 0-3, bank 1 is lanes 4-7). Byte enables of the other half are ignored.
- R9: Both RAS strobes stay high for at least `T_RP` cycles before any RAS strobe falls.
- R10: Once every `T_REFI` cycles, a refresh cycle runs. All CAS strobes fall before both RAS strobes, and WE and OE stay high. A pending refresh is started before a waiting host request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Sequencer idle, request accepted on this edge |
| reqOp | input | 2 | 0 read, 1 write, 2 read-modify-write |
| reqRow | input | 12 | Row address |
| reqCol | input | 12 | Column address |
| reqBank | input | 1 | Bank select used in split mode |
| bankSplit | input | 1 | 1 = two 32-bit banks, 0 = one 64-bit bank |
| reqByteEn | input | 8 | Byte enables, bit i for lane i |
| reqWdata | input | 64 | Write data |
| rdValid | output | 1 | One-cycle read data valid |
| rdData | output | 64 | Read data, unstrobed lanes zero |
| rasN | output | 2 | Row strobes, active low |
| casN | output | 8 | Per-lane column strobes, active low |
| weN | output | 2 | Write strobes per 32-bit half, active low |
| oeN | output | 2 | Output enables per 32-bit half, active low |
| memAddr | output | 12 | Multiplexed row/column address |
| dq | inout | 64 | Memory data bus |

## Verification
The bench uses full-width writes and reads to check the basic store and return path. It then uses partial byte enables, which show whether CAS lanes and the WE and OE halves are picked per lane or per word. It also runs a read-modify-write over previously written data, which shows that the old value comes back while only the enabled bytes change. Split-bank accesses with all enables set show whether the other half's enables are ignored. A long back-to-back request stream, followed by an idle gap, shows whether refresh is still scheduled ahead of queued host work.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_RMW   = 2'd2
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RAS, S_CAS, S_LATE, S_HOLD, S_PRE, S_RCAS, S_RRAS
  } seqState_t;

  // control-to-datapath strobe bundle
  typedef struct packed {
    logic ldReq;    // latch host request fields
    logic rasOn;    // row strobe active
    logic casOn;    // column strobe active
    logic refAll;   // refresh: all lanes, both banks
    logic colSel;   // present column on address bus
    logic weOn;     // write strobe active
    logic oeOn;     // output enable active
    logic drive;    // drive DQ with write data
    logic capture;  // last CAS-low cycle of a read phase
  } ctlStb_t;

endpackage

// File: rtl/dseq_ctrl.sv
module dseq_ctrl
  import dseq_pkg::*;
#(
  parameter int T_RCD  = 2,
  parameter int T_CASW = 3,
  parameter int T_RP   = 3,
  parameter int T_REFI = 200
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  op_e     reqOp,
  output logic    reqReady,
  output ctlStb_t stb
);

  localparam int T_MAX = (T_RCD > T_CASW) ? ((T_RCD > T_RP) ? T_RCD : T_RP)
                                          : ((T_CASW > T_RP) ? T_CASW : T_RP);
  localparam int CNT_W = $clog2(T_MAX + 1);
  localparam int REF_W = $clog2(T_REFI + 1);

  seqState_t state, nxt;
  logic [CNT_W-1:0] cnt, dur;
  logic [REF_W-1:0] refTmr;
  logic refPend, last, accept, startRef;
  op_e  opQ;

  always_comb begin
    case (state)
      S_RAS, S_RCAS:         dur = CNT_W'(T_RCD);
      S_CAS, S_LATE, S_RRAS: dur = CNT_W'(T_CASW);
      S_PRE:                 dur = CNT_W'(T_RP);
      default:               dur = CNT_W'(1);
    endcase
  end

  assign last     = (cnt == dur - 1'b1);
  assign accept   = (state == S_IDLE) && !refPend && reqValid;
  assign startRef = (state == S_IDLE) && refPend;
  assign reqReady = (state == S_IDLE) && !refPend;

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE: if (startRef) nxt = S_RCAS; else if (accept) nxt = S_RAS;
      S_RAS:  if (last) nxt = S_CAS;
      S_CAS:  if (last) nxt = (opQ == OP_RMW) ? S_LATE : S_HOLD;
      S_LATE: if (last) nxt = S_HOLD;
      S_HOLD: nxt = S_PRE;
      S_PRE:  if (last) nxt = S_IDLE;
      S_RCAS: if (last) nxt = S_RRAS;
      S_RRAS: if (last) nxt = S_PRE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      opQ   <= OP_READ;
    end else begin
      state <= nxt;
      cnt   <= (nxt != state) ? '0 : cnt + 1'b1;
      if (accept) opQ <= reqOp;
    end
  end

  // refresh interval timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refTmr  <= '0;
      refPend <= 1'b0;
    end else begin
      if (refTmr == REF_W'(T_REFI - 1)) begin
        refTmr  <= '0;
        refPend <= 1'b1;
      end else begin
        refTmr <= refTmr + 1'b1;
        if (startRef) refPend <= 1'b0;
      end
    end
  end

  always_comb begin
    stb         = '0;
    stb.ldReq   = accept;
    stb.rasOn   = state inside {S_RAS, S_CAS, S_LATE, S_HOLD, S_RRAS};
    stb.casOn   = state inside {S_CAS, S_LATE, S_RCAS, S_RRAS};
    stb.refAll  = state inside {S_RCAS, S_RRAS};
    stb.colSel  = ((state == S_RAS) && last) || (state == S_CAS) || (state == S_LATE);
    stb.weOn    = ((opQ == OP_WRITE) && (state inside {S_RAS, S_CAS})) || (state == S_LATE);
    stb.oeOn    = (state == S_CAS) && (opQ != OP_WRITE);
    stb.drive   = ((state == S_CAS) && (opQ == OP_WRITE)) || (state == S_LATE);
    stb.capture = (state == S_CAS) && last && (opQ != OP_WRITE);
  end

endmodule

// File: rtl/dseq_path.sv
module dseq_path
  import dseq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LANES  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStb_t             stb,
  input  op_e                 reqOp,
  input  logic [ADDR_W-1:0]   reqRow,
  input  logic [ADDR_W-1:0]   reqCol,
  input  logic                reqBank,
  input  logic                bankSplit,
  input  logic [LANES-1:0]    reqByteEn,
  input  logic [LANES*8-1:0]  reqWdata,
  input  logic [LANES*8-1:0]  dqIn,
  output logic [LANES*8-1:0]  dqOut,
  output logic                dqEn,
  output logic [1:0]          rasN,
  output logic [LANES-1:0]    casN,
  output logic [1:0]          weN,
  output logic [1:0]          oeN,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                rdValid,
  output logic [LANES*8-1:0]  rdData
);

  localparam int HALF = LANES / 2;
  localparam logic [LANES-1:0] LO_MASK = {{HALF{1'b0}}, {HALF{1'b1}}};

  logic [ADDR_W-1:0]  rowQ, colQ;
  logic [LANES*8-1:0] wdQ, bitMask;
  logic [LANES-1:0]   laneQ, halfMask;
  logic [1:0]         rasSelQ, halfUse;
  logic               capQ;

  assign halfMask = !bankSplit ? '1 : (reqBank ? ~LO_MASK : LO_MASK);
  assign halfUse  = {|laneQ[LANES-1:HALF], |laneQ[HALF-1:0]};
  assign dqOut    = wdQ;

  for (genvar g = 0; g < LANES; g++) begin : gMask
    assign bitMask[g*8 +: 8] = {8{laneQ[g]}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowQ    <= '0;
      colQ    <= '0;
      wdQ     <= '0;
      laneQ   <= '0;
      rasSelQ <= '0;
    end else if (stb.ldReq) begin
      rowQ    <= reqRow;
      colQ    <= reqCol;
      wdQ     <= reqWdata;
      laneQ   <= (reqOp == OP_READ) ? halfMask : (halfMask & reqByteEn);
      rasSelQ <= !bankSplit ? 2'b11 : (reqBank ? 2'b10 : 2'b01);
    end
  end

  // registered pin drivers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rasN    <= '1;
      casN    <= '1;
      weN     <= '1;
      oeN     <= '1;
      memAddr <= '0;
      dqEn    <= 1'b0;
      capQ    <= 1'b0;
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rasN    <= ~(stb.rasOn ? (stb.refAll ? 2'b11 : rasSelQ) : 2'b00);
      casN    <= ~(stb.casOn ? (stb.refAll ? {LANES{1'b1}} : laneQ) : {LANES{1'b0}});
      weN     <= ~(stb.weOn ? halfUse : 2'b00);
      oeN     <= ~(stb.oeOn ? halfUse : 2'b00);
      memAddr <= stb.colSel ? colQ : rowQ;
      dqEn    <= stb.drive;
      capQ    <= stb.capture;
      rdValid <= capQ;
      if (capQ) rdData <= dqIn & bitMask;
    end
  end

endmodule

// File: rtl/async_dram_seq.sv
module async_dram_seq
  import dseq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LANES  = 8,
  parameter int T_RCD  = 2,
  parameter int T_CASW = 3,
  parameter int T_RP   = 3,
  parameter int T_REFI = 200
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [1:0]          reqOp,
  input  logic [ADDR_W-1:0]   reqRow,
  input  logic [ADDR_W-1:0]   reqCol,
  input  logic                reqBank,
  input  logic                bankSplit,
  input  logic [LANES-1:0]    reqByteEn,
  input  logic [LANES*8-1:0]  reqWdata,
  output logic                rdValid,
  output logic [LANES*8-1:0]  rdData,
  output logic [1:0]          rasN,
  output logic [LANES-1:0]    casN,
  output logic [1:0]          weN,
  output logic [1:0]          oeN,
  output logic [ADDR_W-1:0]   memAddr,
  inout  wire  [LANES*8-1:0]  dq
);

  ctlStb_t            stb;
  logic [LANES*8-1:0] dqOut;
  logic               dqEn;

  assign dq = dqEn ? dqOut : 'z;

  dseq_ctrl #(
    .T_RCD(T_RCD), .T_CASW(T_CASW), .T_RP(T_RP), .T_REFI(T_REFI)
  ) ctrlI (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(op_e'(reqOp)),
    .reqReady(reqReady), .stb(stb)
  );

  dseq_path #(.ADDR_W(ADDR_W), .LANES(LANES)) pathI (
    .clk(clk), .rstN(rstN), .stb(stb), .reqOp(op_e'(reqOp)),
    .reqRow(reqRow), .reqCol(reqCol), .reqBank(reqBank), .bankSplit(bankSplit),
    .reqByteEn(reqByteEn), .reqWdata(reqWdata), .dqIn(dq),
    .dqOut(dqOut), .dqEn(dqEn), .rasN(rasN), .casN(casN), .weN(weN),
    .oeN(oeN), .memAddr(memAddr), .rdValid(rdValid), .rdData(rdData)
  );

endmodule

// File: rtl/async_dram_seq_chk.sv
module async_dram_seq_chk #(
  parameter int LANES = 8,
  parameter int RP    = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqReady,
  input logic             rdValid,
  input logic [1:0]       rasN,
  input logic [LANES-1:0] casN,
  input logic [1:0]       weN,
  input logic [1:0]       oeN,
  input logic             dqEn
);

  int   highCnt;
  logic rasPrevHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highCnt     <= RP;
      rasPrevHigh <= 1'b1;
    end else begin
      rasPrevHigh <= (rasN == 2'b11);
      if (rasN == 2'b11) highCnt <= (highCnt >= RP) ? RP : highCnt + 1;
      else               highCnt <= 0;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (rasN == 2'b11 && casN == '1 && weN == 2'b11 && oeN == 2'b11 && !dqEn));

  // R4
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  // R4
  dq_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    dqEn |-> (weN != 2'b11));

  // R5
  we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (weN != 2'b11) |-> ((~weN & ~oeN) == 2'b00));

  // R9
  precharge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rasPrevHigh && rasN != 2'b11) |-> (highCnt >= RP));

  // R10
  cbr_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (casN != '1 && rasN == 2'b11) |-> (weN == 2'b11 && oeN == 2'b11));

endmodule

bind async_dram_seq async_dram_seq_chk #(.LANES(LANES), .RP(T_RP)) chkI (.*);

// File: tb/async_dram_seq_test.sv
`timescale 1ns/1ps
module async_dram_seq_test;

  localparam int RCD = 2, CASW = 3, RP = 3, REFI = 200;

  logic        clk = 0, rstN = 0;
  logic        reqValid = 0, reqBank = 0, bankSplit = 0;
  logic [1:0]  reqOp = 0;
  logic [11:0] reqRow = 0, reqCol = 0;
  logic [7:0]  reqByteEn = 0;
  logic [63:0] reqWdata = 0;
  logic        reqReady, rdValid;
  logic [63:0] rdData;
  logic [1:0]  rasN, weN, oeN;
  logic [7:0]  casN;
  logic [11:0] memAddr;
  wire  [63:0] dq;

  int checks = 0, fails = 0, cyc = 0;
  int refCnt = 0, earlyCnt = 0, lateCnt = 0;
  logic [63:0] expQ[$];
  logic [63:0] shadow[bit [23:0]];
  logic [63:0] mem[bit [23:0]];
  logic [63:0] memOut = 0;
  logic [11:0] curRow = 0, curCol = 0, expRow = 0, expCol = 0;
  logic [7:0]  expLanes = 0;
  logic [1:0]  expRas = 3, expWe = 3, expOe = 3;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  async_dram_seq #(.T_RCD(RCD), .T_CASW(CASW), .T_RP(RP), .T_REFI(REFI)) uut (.*);

  for (genvar g = 0; g < 8; g++) begin : gMem
    assign dq[g*8 +: 8] = (!casN[g] && weN[g/4] && !oeN[g/4]) ? memOut[g*8 +: 8] : 8'hzz;
  end

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [63:0] bm(input logic [7:0] l);
    logic [63:0] m;
    for (int i = 0; i < 8; i++) m[i*8 +: 8] = {8{l[i]}};
    return m;
  endfunction

  // memory model: latches addresses, serves reads, stores writes
  int rasFallCyc = 0, highRun = 100;
  logic [1:0] prevRas = 3, prevWe = 3;
  logic [7:0] prevCas = 8'hFF;
  always @(negedge clk) begin
    if (rstN) begin
      if (rasN != 2'b11 && prevRas == 2'b11) begin
        chk(highRun >= RP, "R9 precharge before RAS fall", highRun, RP);
        if (casN == 8'h00) begin
          refCnt++;
          chk(weN == 2'b11 && oeN == 2'b11, "R10 refresh WE/OE high", {weN, oeN}, 4'hF);
        end else begin
          curRow = memAddr; rasFallCyc = cyc;
          chk(rasN == expRas, "R8 RAS select", rasN, expRas);
          chk(memAddr == expRow, "R2 row address", memAddr, expRow);
        end
      end
      if (casN != 8'hFF && prevCas == 8'hFF && rasN != 2'b11) begin
        curCol = memAddr;
        chk(memAddr == expCol, "R2 column address", memAddr, expCol);
        chk(cyc - rasFallCyc == RCD, "R2 RAS-to-CAS delay", cyc - rasFallCyc, RCD);
        chk(~casN == expLanes, "R6 CAS lanes", ~casN, expLanes);
        chk(weN == expWe, "R7 WE halves", weN, expWe);
        chk(oeN == expOe, "R7 OE halves", oeN, expOe);
        if (weN != 2'b11) earlyCnt++;
        memOut = mem.exists({curRow, curCol}) ? mem[{curRow, curCol}] : 64'h0;
      end
      if ((prevWe & ~weN) != 0 && casN != 8'hFF && prevCas != 8'hFF) lateCnt++;
      for (int i = 0; i < 8; i++)
        if (!casN[i] && !weN[i/4] && rasN != 2'b11) begin
          logic [63:0] v;
          v = mem.exists({curRow, curCol}) ? mem[{curRow, curCol}] : 64'h0;
          v[i*8 +: 8] = dq[i*8 +: 8];
          mem[{curRow, curCol}] = v;
        end
      highRun = (rasN == 2'b11) ? highRun + 1 : 0;
      prevRas = rasN; prevCas = casN; prevWe = weN;
    end
  end

  // scoreboard monitor
  logic prevRdV = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (rdValid) begin
        if (expQ.size() == 0) chk(0, "R4 unexpected read data", rdData, 0);
        else begin
          logic [63:0] e;
          e = expQ.pop_front();
          chk(rdData == e, "R4 read data", rdData, e);
        end
      end
      if (rdValid && prevRdV) chk(0, "R4 rdValid pulse width", 2, 1);
      prevRdV = rdValid;
    end
  end

  task automatic issue(input logic [1:0] op, input logic [11:0] row, input logic [11:0] col,
                       input bit split, input bit bank, input logic [7:0] be, input logic [63:0] wd);
    logic [7:0] half, lanes;
    logic [1:0] use2;
    logic [63:0] old, m;
    half  = !split ? 8'hFF : (bank ? 8'hF0 : 8'h0F);
    lanes = (op == 0) ? half : (half & be);
    use2  = {|lanes[7:4], |lanes[3:0]};
    m     = bm(lanes);
    old   = shadow.exists({row, col}) ? shadow[{row, col}] : 64'h0;
    if (op != 0) shadow[{row, col}] = (old & ~m) | (wd & m);
    if (op != 1) expQ.push_back(old & m);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    expRow = row; expCol = col; expLanes = lanes;
    expRas = ~(!split ? 2'b11 : (bank ? 2'b10 : 2'b01));
    expWe  = (op == 1) ? ~use2 : 2'b11;
    expOe  = (op == 1) ? 2'b11 : ~use2;
    reqOp = op; reqRow = row; reqCol = col; bankSplit = split; reqBank = bank;
    reqByteEn = be; reqWdata = wd; reqValid = 1;
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
    while (!reqReady || expQ.size() != 0) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int e0, l0, r0, c0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(rasN == 2'b11 && casN == 8'hFF && weN == 2'b11 && oeN == 2'b11, "R1 strobes high in reset",
        {rasN, casN, weN, oeN}, 14'h3FFF);
    rstN = 1;
    @(negedge clk);
    chk(reqReady == 1, "R1 ready after reset", reqReady, 1);
    // R3 full write then R4 read
    issue(1, 12'h005, 12'h007, 0, 0, 8'hFF, 64'h1122_3344_5566_7788);
    @(negedge clk);
    chk(reqReady == 0, "R1 ready low while busy", reqReady, 0);
    issue(0, 12'h005, 12'h007, 0, 0, 8'h00, 64'h0);
    // R6 partial write low half, read merge
    issue(1, 12'h005, 12'h007, 0, 0, 8'h0F, 64'hAAAA_AAAA_BBBB_BBBB);
    issue(0, 12'h005, 12'h007, 0, 0, 8'h00, 64'h0);
    // R6/R7 scattered lanes
    issue(1, 12'h009, 12'h003, 0, 0, 8'hA5, 64'hF0E1_D2C3_B4A5_9687);
    issue(0, 12'h009, 12'h003, 0, 0, 8'h00, 64'h0);
    drain();
    e0 = earlyCnt; l0 = lateCnt;
    // R5 read-modify-write high half
    issue(2, 12'h005, 12'h007, 0, 0, 8'hF0, 64'hCAFE_F00D_0000_0000);
    issue(0, 12'h005, 12'h007, 0, 0, 8'h00, 64'h0);
    drain();
    chk(lateCnt - l0 == 1, "R5 late write event", lateCnt - l0, 1);
    chk(earlyCnt == e0, "R3 no early write in RMW", earlyCnt, e0);
    // R8 split bank, other half enables ignored
    issue(1, 12'h002, 12'h002, 1, 1, 8'hFF, 64'h0102_0304_0506_0708);
    issue(1, 12'h003, 12'h003, 1, 0, 8'hFF, 64'h1112_1314_1516_1718);
    issue(0, 12'h002, 12'h002, 0, 0, 8'h00, 64'h0);
    issue(0, 12'h003, 12'h003, 0, 0, 8'h00, 64'h0);
    issue(0, 12'h002, 12'h002, 1, 0, 8'h00, 64'h0);
    drain();
    chk(earlyCnt - e0 == 2, "R3 early write events", earlyCnt - e0, 2);
    // R10 back-to-back stream: refresh keeps priority
    r0 = refCnt; c0 = cyc;
    for (int i = 0; i < 60; i++) begin
      logic [7:0] be;
      be = 8'(i * 37 + 1) | 8'h01;
      issue(2'(i % 3), 12'(i % 4), 12'((i * 5) % 8), 0, 0, be, {32'(i * 977), 32'(i * 13 + 5)});
    end
    drain();
    chk(refCnt - r0 >= (cyc - c0) / REFI - 1, "R10 refresh under load", refCnt - r0, (cyc - c0) / REFI - 1);
    // R10 idle refresh
    r0 = refCnt;
    repeat (2 * REFI + 20) @(negedge clk);
    chk(refCnt - r0 >= 2, "R10 idle refresh count", refCnt - r0, 2);
    for (int i = 0; i < 4; i++) issue(0, 12'(i), 12'(i * 5 % 8), 0, 0, 8'h00, 64'h0);
    drain();
    chk(expQ.size() == 0, "R4 all reads returned", expQ.size(), 0);
    finishRun();
  end

endmodule